// File: doc/BRIEF.md
# POST-Code Port Router with Per-Interface Shadows

This block sits on an 8-bit I/O address path and claims a small set of diagnostic progress-code ports. A write to one of the eight base ports (80h, 84h, 85h, 86h, 88h, 8Ch, 8Dh, 8Eh) goes out as a one-cycle write strobe on downstream interface A or interface B. The choice follows a route-select input that is sampled with the request. Eight alias ports (base + 10h) always go to interface A, whatever the route select says.

Every forwarded write is also stored in a shadow register. Each interface has its own bank of shadows. Reads of claimed ports are never forwarded. They are answered from the bank of the interface that a write to the same address would reach. Because the banks are separate, changing the route select makes reads return the other interface's last value, not the newest write overall. Addresses outside both sets are not claimed, and this is reported on a no-claim pulse.

Top module: `postrt_router`

## Requirements
- R1: After reset, every output is 0, and every shadow in both banks reads back 00h.
- R2: A write to a base port with route_sel=0 gives, one clock later, a single-cycle a_wr_stb with a_wr_addr equal to the request address and a_wr_data equal to the write data. b_wr_stb stays 0.
- R3: A write to a base port with route_sel=1 gives, one clock later, a single-cycle b_wr_stb with the request address and data. a_wr_stb stays 0.
- R4: A write to an alias port (90h, 94h, 95h, 96h, 98h, 9Ch, 9Dh, 9Eh) always raises a_wr_stb one clock later, whatever the value of route_sel. The forwarded address is the alias address itself.
- R5: A read of a claimed port raises rd_valid for one cycle, one clock after the request, with rd_data taken from the shadow. A read raises no write strobe.
- R6: The shadows are kept per interface. A base-port read with route_sel=0 returns the last value written to interface A for that port. With route_sel=1 it returns the last value written to interface B.
- R7: An alias port shares its shadow entry with its base port (address − 10h) in bank A. A read of an alias returns the bank A value, even when route_sel=1.
- R8: A request to any other address raises no write strobe and no rd_valid, and leaves both banks unchanged. It raises no_claim for one cycle, one clock after the request.
- R9: Each of the eight base ports has its own storage. Writing all eight with distinct values and reading them back returns each value at its own port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | I/O port address |
| req_wdata | input | 8 | Write data |
| route_sel | input | 1 | Base-port routing: 0 = interface A, 1 = interface B |
| a_wr_stb | output | 1 | Interface A write strobe |
| a_wr_addr | output | 8 | Interface A write address |
| a_wr_data | output | 8 | Interface A write data |
| b_wr_stb | output | 1 | Interface B write strobe |
| b_wr_addr | output | 8 | Interface B write address |
| b_wr_data | output | 8 | Interface B write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data from a shadow |
| no_claim | output | 1 | The previous request hit no claimed port |

## Verification
The bench writes the same port through both interfaces and then reads it under each route setting. A design with one shared shadow would return the newest write in both cases and fail R6. It also writes through an alias while route_sel=1 and then reads the base port in bank A and the alias itself. A design that let the route select steer aliases, or that kept aliases in storage of their own, would show the data on interface B or read back 00h. Unclaimed neighbours such as 81h, 8Fh and A0h are followed by a read of a real port, so a loose decoder that corrupts a shadow or raises a strobe is caught.

// File: rtl/postrt_pkg.sv
package postrt_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int NUM_PORTS = 8;
    localparam int IDX_W     = $clog2(NUM_PORTS);
    localparam int NUM_IF    = 2;

    typedef enum logic [1:0] {
        SPACE_NONE  = 2'd0,
        SPACE_BASE  = 2'd1,
        SPACE_ALIAS = 2'd2
    } space_e;

    typedef enum logic {
        IF_A = 1'b0,
        IF_B = 1'b1
    } if_sel_e;

    typedef struct packed {
        space_e           space;
        logic [IDX_W-1:0] idx;
    } decode_t;

    typedef struct packed {
        logic              stb;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } fwd_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } slot_t;

    // Low-nibble to shadow slot: 0,4,5,6,8,C,D,E map to slots 0..7
    function automatic slot_t nibble_slot(input logic [3:0] nib);
        slot_t s;
        s.hit = 1'b1;
        s.idx = '0;
        case (nib)
            4'h0: s.idx = 3'd0;
            4'h4: s.idx = 3'd1;
            4'h5: s.idx = 3'd2;
            4'h6: s.idx = 3'd3;
            4'h8: s.idx = 3'd4;
            4'hC: s.idx = 3'd5;
            4'hD: s.idx = 3'd6;
            4'hE: s.idx = 3'd7;
            default: s.hit = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/postrt_decode.sv
module postrt_decode
    import postrt_pkg::*;
#(
    parameter logic [3:0] BASE_PAGE  = 4'h8,
    parameter logic [3:0] ALIAS_PAGE = 4'h9
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    slot_t slot;

    always_comb begin
        slot      = nibble_slot(addr[3:0]);
        dec.idx   = slot.idx;
        dec.space = SPACE_NONE;
        if (slot.hit) begin
            if (addr[ADDR_W-1:4] == BASE_PAGE)
                dec.space = SPACE_BASE;
            else if (addr[ADDR_W-1:4] == ALIAS_PAGE)
                dec.space = SPACE_ALIAS;
        end
    end
endmodule

// File: rtl/postrt_shadow.sv
module postrt_shadow
    import postrt_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int DEPTH = NUM_PORTS,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (we && widx == IW'(i))
                mem[i] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/postrt_egress.sv
module postrt_egress
    import postrt_pkg::*;
#(
    parameter int N = NUM_IF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      wr_fire,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_fire,
    input  logic [DATA_W-1:0] rd_src,
    input  logic              miss,
    output fwd_t              fwd [N],
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              no_claim
);
    for (genvar i = 0; i < N; i++) begin : g_if
        always_ff @(posedge clk) begin
            if (rst) begin
                fwd[i] <= '0;
            end else begin
                fwd[i].stb <= wr_fire[i];
                if (wr_fire[i]) begin
                    fwd[i].addr <= addr;
                    fwd[i].data <= wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            no_claim <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
            no_claim <= miss;
            if (rd_fire)
                rd_data <= rd_src;
        end
    end
endmodule

// File: rtl/postrt_router.sv
module postrt_router
    import postrt_pkg::*;
#(
    parameter logic [3:0] BASE_PAGE  = 4'h8,
    parameter logic [3:0] ALIAS_PAGE = 4'h9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              route_sel,
    output logic              a_wr_stb,
    output logic [ADDR_W-1:0] a_wr_addr,
    output logic [DATA_W-1:0] a_wr_data,
    output logic              b_wr_stb,
    output logic [ADDR_W-1:0] b_wr_addr,
    output logic [DATA_W-1:0] b_wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              no_claim
);
    decode_t           dec;
    if_sel_e           tgt;
    logic              claimed;
    logic [NUM_IF-1:0] wr_fire;
    logic [DATA_W-1:0] bank_rd [NUM_IF];
    fwd_t              fwd [NUM_IF];

    postrt_decode #(.BASE_PAGE(BASE_PAGE), .ALIAS_PAGE(ALIAS_PAGE)) u_dec (
        .addr(req_addr),
        .dec (dec)
    );

    assign claimed = (dec.space != SPACE_NONE);
    assign tgt     = (dec.space == SPACE_ALIAS) ? IF_A : if_sel_e'(route_sel);

    for (genvar i = 0; i < NUM_IF; i++) begin : g_bank
        assign wr_fire[i] = req_valid && req_write && claimed && (tgt == if_sel_e'(i));

        postrt_shadow #(.W(DATA_W), .DEPTH(NUM_PORTS)) u_shadow (
            .clk  (clk),
            .rst  (rst),
            .we   (wr_fire[i]),
            .widx (dec.idx),
            .wdata(req_wdata),
            .ridx (dec.idx),
            .rdata(bank_rd[i])
        );
    end

    postrt_egress #(.N(NUM_IF)) u_egress (
        .clk     (clk),
        .rst     (rst),
        .wr_fire (wr_fire),
        .addr    (req_addr),
        .wdata   (req_wdata),
        .rd_fire (req_valid && !req_write && claimed),
        .rd_src  (bank_rd[tgt]),
        .miss    (req_valid && !claimed),
        .fwd     (fwd),
        .rd_valid(rd_valid),
        .rd_data (rd_data),
        .no_claim(no_claim)
    );

    assign a_wr_stb  = fwd[IF_A].stb;
    assign a_wr_addr = fwd[IF_A].addr;
    assign a_wr_data = fwd[IF_A].data;
    assign b_wr_stb  = fwd[IF_B].stb;
    assign b_wr_addr = fwd[IF_B].addr;
    assign b_wr_data = fwd[IF_B].data;
endmodule

// File: rtl/postrt_router_chk.sv
module postrt_router_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_write,
    input logic [7:0] req_addr,
    input logic       route_sel,
    input logic       a_wr_stb,
    input logic [7:0] a_wr_addr,
    input logic       b_wr_stb,
    input logic [7:0] b_wr_addr,
    input logic       rd_valid,
    input logic       no_claim
);
    // R2/R3: at most one interface is written per request
    assert_single_target_R2: assert property (@(posedge clk) disable iff (rst)
        !(a_wr_stb && b_wr_stb));

    // R3: a strobe on B needs a write with route_sel=1 on the previous cycle
    assert_b_needs_route_R3: assert property (@(posedge clk) disable iff (rst)
        b_wr_stb |-> $past(req_valid && req_write && route_sel));

    // R4: aliases never reach B
    assert_alias_not_b_R4: assert property (@(posedge clk) disable iff (rst)
        b_wr_stb |-> b_wr_addr[7:4] == 4'h8);

    // R2/R4: a strobe on A comes from route_sel=0 or from an alias
    assert_a_origin_R2: assert property (@(posedge clk) disable iff (rst)
        a_wr_stb |-> $past(req_valid && req_write)
                     && ($past(!route_sel) || a_wr_addr[7:4] == 4'h9));

    // R5: read data follows a read request by one cycle
    assert_read_latency_R5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(req_valid && !req_write));

    // R5: reads never drive a strobe
    assert_read_no_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> !a_wr_stb && !b_wr_stb);

    // R8: an unclaimed request stays quiet
    assert_miss_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        no_claim |-> !a_wr_stb && !b_wr_stb && !rd_valid);

    // R8: no_claim only follows a request
    assert_miss_origin_R8: assert property (@(posedge clk) disable iff (rst)
        no_claim |-> $past(req_valid) && $past(req_addr[7:4]) != 4'h8
                     || $past(req_valid) && $past(req_addr[3:0]) inside
                        {4'h1, 4'h2, 4'h3, 4'h7, 4'h9, 4'hA, 4'hB, 4'hF});
endmodule

bind postrt_router postrt_router_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .route_sel(route_sel),
    .a_wr_stb (a_wr_stb),
    .a_wr_addr(a_wr_addr),
    .b_wr_stb (b_wr_stb),
    .b_wr_addr(b_wr_addr),
    .rd_valid (rd_valid),
    .no_claim (no_claim)
);

// File: tb/postrt_router_bench.sv
module postrt_router_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [7:0] req_addr  = '0;
    logic [7:0] req_wdata = '0;
    logic       route_sel = 1'b0;
    logic       a_wr_stb, b_wr_stb, rd_valid, no_claim;
    logic [7:0] a_wr_addr, a_wr_data, b_wr_addr, b_wr_data, rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    postrt_router u_postrt_router (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .route_sel(route_sel),
        .a_wr_stb(a_wr_stb), .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
        .b_wr_stb(b_wr_stb), .b_wr_addr(b_wr_addr), .b_wr_data(b_wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .no_claim(no_claim)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at negedge; the outputs are registered, so sample at the next negedge
    task automatic issue(input bit wr, input logic [7:0] a, input logic [7:0] d, input bit r);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; route_sel = r;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic write_to_a(input logic [7:0] a, input logic [7:0] d, input bit r, input string req);
        issue(1'b1, a, d, r);
        check(a_wr_stb && !b_wr_stb && a_wr_addr == a && a_wr_data == d && !no_claim,
              req, {a_wr_stb, b_wr_stb, a_wr_addr, a_wr_data}, {2'b10, a, d});
    endtask

    task automatic write_to_b(input logic [7:0] a, input logic [7:0] d, input string req);
        issue(1'b1, a, d, 1'b1);
        check(b_wr_stb && !a_wr_stb && b_wr_addr == a && b_wr_data == d && !no_claim,
              req, {a_wr_stb, b_wr_stb, b_wr_addr, b_wr_data}, {2'b01, a, d});
    endtask

    task automatic read_expect(input logic [7:0] a, input bit r, input logic [7:0] exp, input string req);
        issue(1'b0, a, 8'h00, r);
        check(rd_valid && rd_data == exp && !a_wr_stb && !b_wr_stb && !no_claim,
              req, {rd_valid, a_wr_stb, b_wr_stb, rd_data}, {3'b100, exp});
    endtask

    task automatic miss_expect(input bit wr, input logic [7:0] a, input string req);
        issue(wr, a, 8'hEE, 1'b0);
        check(no_claim && !rd_valid && !a_wr_stb && !b_wr_stb,
              req, {no_claim, rd_valid, a_wr_stb, b_wr_stb}, 4'b1000);
    endtask

    task automatic t_reset;
        check(!a_wr_stb && !b_wr_stb && !rd_valid && !no_claim, "R1 outputs",
              {a_wr_stb, b_wr_stb, rd_valid, no_claim}, 0);
        read_expect(8'h80, 1'b0, 8'h00, "R1 bank A clear");
        read_expect(8'h8E, 1'b1, 8'h00, "R1 bank B clear");
    endtask

    task automatic t_route;
        write_to_a(8'h80, 8'h11, 1'b0, "R2 route A");
        @(negedge clk);
        check(!a_wr_stb, "R2 single cycle strobe", a_wr_stb, 0);
        read_expect(8'h80, 1'b0, 8'h11, "R5 read shadow A");
        write_to_b(8'h80, 8'h22, "R3 route B");
        read_expect(8'h80, 1'b1, 8'h22, "R6 bank B value");
        read_expect(8'h80, 1'b0, 8'h11, "R6 bank A value after flip");
    endtask

    task automatic t_alias;
        write_to_a(8'h94, 8'h33, 1'b1, "R4 alias to A under route 1");
        read_expect(8'h84, 1'b0, 8'h33, "R7 alias shares base slot");
        read_expect(8'h94, 1'b1, 8'h33, "R7 alias read from bank A");
        read_expect(8'h84, 1'b1, 8'h00, "R7 bank B untouched");
    endtask

    task automatic t_all_ports;
        logic [7:0] ports [8] = '{8'h80, 8'h84, 8'h85, 8'h86, 8'h88, 8'h8C, 8'h8D, 8'h8E};
        for (int i = 0; i < 8; i++) write_to_a(ports[i], 8'hA0 + 8'(i), 1'b0, "R9 write");
        for (int i = 0; i < 8; i++) read_expect(ports[i], 1'b0, 8'hA0 + 8'(i), "R9 readback");
    endtask

    task automatic t_miss;
        miss_expect(1'b1, 8'h81, "R8 write 81h");
        miss_expect(1'b1, 8'h8F, "R8 write 8Fh");
        miss_expect(1'b1, 8'hA0, "R8 write A0h");
        miss_expect(1'b0, 8'h91, "R8 read 91h");
        read_expect(8'h80, 1'b0, 8'hA0, "R8 bank A unchanged");
        read_expect(8'h8E, 1'b0, 8'hA7, "R8 bank A 8Eh unchanged");
        read_expect(8'h80, 1'b1, 8'h22, "R8 bank B unchanged");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_route();
        t_alias();
        t_all_ports();
        t_miss();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule